// File: doc/BRIEF.md
# Slot Table Builder

This engine turns a per-client bandwidth configuration into the slot table that a time-slotted memory arbiter works from. Each client supplies an active flag and a count of slots it wants. The engine also takes a pool of spare slots. Software or a control block loads these values and pulses `start`. The engine then builds the table in an internal scratch store and streams it out as one (slot, client) write per cycle. After that it signals completion.

The table is built in two passes. The first pass walks the clients from the lowest index to the highest. A client that asks for slots has them spread across the table at an even stride; an entry that is already taken pushes the claim on to the next free entry. An active client that asks for nothing is handed a single entry, but only while the spare pool lasts. The second pass runs while the table is streamed out. Every entry still empty goes to the active clients in turn, under a rotating pointer. A configuration whose requests add up to more than the table holds is turned away at `start`.

Top module: `slot_table_builder`

## Requirements
- R1: After reset the engine is idle: `wr_valid`, `done` and `refused` are all low, and they stay low until `start` is pulsed.
- R2: At `start` the engine adds up all requested slot counts. If the total exceeds 64, `refused` pulses for one cycle and no write and no `done` follow. A total of exactly 64 is accepted.
- R3: Clients are placed in ascending index order. A client with a nonzero request R is placed whether or not it is active. Its stride is floor(64/R). A cursor starts at entry 0. An occupied entry moves the cursor on by one. An empty entry is given to the client and moves the cursor on by the stride. The client is finished once the cursor reaches 64.
- R4: An active client whose request is zero is placed with a stride of 64, so it gets exactly one entry (the first empty one). This happens only while the spare count loaded at `start` is above zero, and each such grant lowers that count by one.
- R5: In the placement pass the engine skips an inactive client with a zero request. It also skips a zero-request client once the spare count has reached zero.
- R6: In the fill pass each empty entry goes to the first active client found from a rotating pointer, searching upward and wrapping after client 14. The pointer starts at client 0 and then moves to the client just after the one assigned.
- R7: If no client is active, an empty entry goes to the client the pointer holds, and the pointer still advances by one. A table with no requests and no active clients therefore reads slot k → client k mod 15.
- R8: The table is emitted as exactly 64 writes with `wr_valid` high. They run in ascending slot order from 0 to 63, one per consecutive cycle, and `wr_client` is always below 15.
- R9: `done` is high for exactly one cycle, in the cycle right after the write of slot 63.
- R10: A `start` pulse that arrives while a build is under way is ignored. The running table is finished from the configuration loaded at its own start, and no further run follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a build; sampled only when idle |
| client_active | input | 15 | Active flag, one bit per client (bit i is client i) |
| client_req | input | 105 | Requested slot counts, 7 bits per client; client i at bits [7i+6:7i] |
| spare_slots | input | 7 | Spare entries that zero-request active clients may take |
| wr_valid | output | 1 | A table write is presented this cycle |
| wr_slot | output | 6 | Slot index of the write |
| wr_client | output | 4 | Client assigned to that slot |
| done | output | 1 | One-cycle pulse after the final write |
| refused | output | 1 | One-cycle pulse when a configuration is turned away |

## Verification
The scratch store is read back in full during every build, so any wrong state inside it shows up at the ports. A misplaced stride, a lost spare count or a bad skip decision shifts at least one `wr_client` value in the 64-write stream. That error appears within 64 cycles of the fill pass starting. A wrong rotating pointer changes the client on the first empty entry after the fault. A wrong slot counter breaks the ascending sequence, or moves `done` away from the cycle after slot 63. Each scenario compares the whole streamed table against a table computed from the requirements.

// File: rtl/slot_tbl_pkg.sv
package slot_tbl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_PLACE,
      ST_FILL,
      ST_DONE
   } build_state_t;

endpackage

// File: rtl/slot_stride_calc.sv
module slot_stride_calc #(
   parameter int NUM_SLOTS = 64,
   parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
   input  logic [CNT_W-1:0] req,
   output logic [CNT_W-1:0] stride
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);

   // A zero request means a single entry: a stride of the whole table.
   always_comb begin
      if (req == '0) stride = FULL;
      else           stride = FULL / req;
   end
endmodule

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
   parameter int NUM_CLIENTS = 15,
   parameter int ID_W        = $clog2(NUM_CLIENTS + 1)
) (
   input  logic [NUM_CLIENTS-1:0] active,
   input  logic [ID_W-1:0]        ptr,
   output logic [ID_W-1:0]        pick,
   output logic [ID_W-1:0]        next_ptr
);
   localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_CLIENTS - 1);

   // Search upward from ptr with wrap; fall back to ptr when none active.
   always_comb begin
      logic found;
      int   idx;
      pick  = ptr;
      found = 1'b0;
      for (int k = 0; k < NUM_CLIENTS; k++) begin
         idx = int'(ptr) + k;
         if (idx >= NUM_CLIENTS) idx = idx - NUM_CLIENTS;
         if (!found && active[idx]) begin
            pick  = ID_W'(idx);
            found = 1'b1;
         end
      end
      next_ptr = (pick == LAST_ID) ? '0 : pick + 1'b1;
   end
endmodule

// File: rtl/slot_scratch.sv
module slot_scratch #(
   parameter int DEPTH    = 64,
   parameter int ID_W     = 4,
   parameter int EMPTY_ID = 15,
   parameter int ADDR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [ID_W-1:0]   wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [ID_W-1:0]   rdata
);
   localparam logic [ID_W-1:0] EMPTY = ID_W'(EMPTY_ID);

   logic [ID_W-1:0] ent [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              ent[e] <= EMPTY;
            else if (clr)                            ent[e] <= EMPTY;
            else if (we && waddr == ADDR_W'(e))      ent[e] <= wdata;
         end
      end
   endgenerate

   assign rdata = ent[raddr];

   // Placement only ever claims an empty entry.
   assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |-> (ent[waddr] == EMPTY));
endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder
   import slot_tbl_pkg::*;
#(
   parameter int NUM_CLIENTS = 15,
   parameter int NUM_SLOTS   = 64
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic                                            start,
   input  logic [NUM_CLIENTS-1:0]                          client_active,
   input  logic [NUM_CLIENTS*$clog2(NUM_SLOTS+1)-1:0]      client_req,
   input  logic [$clog2(NUM_SLOTS+1)-1:0]                  spare_slots,
   output logic                                            wr_valid,
   output logic [$clog2(NUM_SLOTS)-1:0]                    wr_slot,
   output logic [$clog2(NUM_CLIENTS+1)-1:0]                wr_client,
   output logic                                            done,
   output logic                                            refused
);
   localparam int CNT_W  = $clog2(NUM_SLOTS + 1);
   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int CID_W  = $clog2(NUM_CLIENTS + 1);
   localparam int POS_W  = CNT_W + 1;
   localparam int SUM_W  = CNT_W + CID_W;
   localparam logic [CID_W-1:0]  EMPTY     = CID_W'(NUM_CLIENTS);
   localparam logic [CID_W-1:0]  LAST_CID  = CID_W'(NUM_CLIENTS - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [POS_W-1:0]  POS_END   = POS_W'(NUM_SLOTS);
   localparam logic [SUM_W-1:0]  SUM_MAX   = SUM_W'(NUM_SLOTS);

   generate
      if (NUM_CLIENTS < 1 || NUM_SLOTS < 2)
         $error("slot_table_builder: need at least one client and two slots");
      if (NUM_SLOTS > (1 << SLOT_W))
         $error("slot_table_builder: slot index width too narrow");
   endgenerate

   build_state_t     state;
   logic [NUM_CLIENTS-1:0] act_q;
   logic [CNT_W-1:0] req_q [NUM_CLIENTS];
   logic [CNT_W-1:0] spare_q;
   logic [CID_W-1:0] cur;
   logic [POS_W-1:0] pos;
   logic [CNT_W-1:0] stride_q;
   logic [SLOT_W-1:0] slot_idx;
   logic [CID_W-1:0] rr_ptr;

   // Total of all requests, for the admission check at start.
   logic [SUM_W-1:0] req_sum;
   always_comb begin
      req_sum = '0;
      for (int i = 0; i < NUM_CLIENTS; i++)
         req_sum = req_sum + SUM_W'(client_req[i*CNT_W +: CNT_W]);
   end

   logic accept, overbooked;
   assign overbooked = (req_sum > SUM_MAX);
   assign accept     = (state == ST_IDLE) && start && !overbooked;

   // Stride for the current client.
   logic [CNT_W-1:0] cur_req, cur_stride;
   assign cur_req = req_q[cur];

   slot_stride_calc #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_stride (
      .req    (cur_req),
      .stride (cur_stride)
   );

   // Scratch table.
   logic              sc_we;
   logic [SLOT_W-1:0] sc_raddr;
   logic [CID_W-1:0]  sc_rdata;
   logic              pos_live;

   assign pos_live = (pos < POS_END);
   assign sc_we    = (state == ST_PLACE) && pos_live && (sc_rdata == EMPTY);
   assign sc_raddr = (state == ST_FILL) ? slot_idx : pos[SLOT_W-1:0];

   slot_scratch #(
      .DEPTH(NUM_SLOTS), .ID_W(CID_W), .EMPTY_ID(NUM_CLIENTS), .ADDR_W(SLOT_W)
   ) u_scratch (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .we    (sc_we),
      .waddr (pos[SLOT_W-1:0]),
      .wdata (cur),
      .raddr (sc_raddr),
      .rdata (sc_rdata)
   );

   // Round-robin choice for empty entries in the fill pass.
   logic [CID_W-1:0] rr_pick, rr_next;

   slot_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS), .ID_W(CID_W)) u_rr (
      .active   (act_q),
      .ptr      (rr_ptr),
      .pick     (rr_pick),
      .next_ptr (rr_next)
   );

   logic cur_last;
   assign cur_last = (cur == LAST_CID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         act_q     <= '0;
         spare_q   <= '0;
         cur       <= '0;
         pos       <= '0;
         stride_q  <= '0;
         slot_idx  <= '0;
         rr_ptr    <= '0;
         wr_valid  <= 1'b0;
         wr_slot   <= '0;
         wr_client <= '0;
         done      <= 1'b0;
         refused   <= 1'b0;
         for (int i = 0; i < NUM_CLIENTS; i++) req_q[i] <= '0;
      end else begin
         wr_valid <= 1'b0;
         done     <= 1'b0;
         refused  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start && overbooked) begin
                  refused <= 1'b1;
               end else if (accept) begin
                  act_q   <= client_active;
                  spare_q <= spare_slots;
                  for (int i = 0; i < NUM_CLIENTS; i++)
                     req_q[i] <= client_req[i*CNT_W +: CNT_W];
                  cur   <= '0;
                  state <= ST_PICK;
               end
            end
            ST_PICK: begin
               stride_q <= cur_stride;
               pos      <= '0;
               if (cur_req != '0) begin
                  state <= ST_PLACE;
               end else if (act_q[cur] && spare_q != '0) begin
                  spare_q <= spare_q - 1'b1;
                  state   <= ST_PLACE;
               end else if (cur_last) begin
                  slot_idx <= '0;
                  rr_ptr   <= '0;
                  state    <= ST_FILL;
               end else begin
                  cur <= cur + 1'b1;
               end
            end
            ST_PLACE: begin
               if (!pos_live) begin
                  if (cur_last) begin
                     slot_idx <= '0;
                     rr_ptr   <= '0;
                     state    <= ST_FILL;
                  end else begin
                     cur   <= cur + 1'b1;
                     state <= ST_PICK;
                  end
               end else if (sc_rdata != EMPTY) begin
                  pos <= pos + 1'b1;
               end else begin
                  pos <= pos + POS_W'(stride_q);
               end
            end
            ST_FILL: begin
               wr_valid <= 1'b1;
               wr_slot  <= slot_idx;
               if (sc_rdata == EMPTY) begin
                  wr_client <= rr_pick;
                  rr_ptr    <= rr_next;
               end else begin
                  wr_client <= sc_rdata;
               end
               if (slot_idx == LAST_SLOT) state <= ST_DONE;
               else                       slot_idx <= slot_idx + 1'b1;
            end
            ST_DONE: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_stream_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && $past(wr_valid)) |-> (wr_slot == $past(wr_slot) + 1'b1));

   assert_stream_unbroken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_slot != LAST_SLOT) |=> wr_valid);

   assert_client_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_client < EMPTY));

   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_valid) && $past(wr_slot) == LAST_SLOT && !wr_valid));

   assert_refuse_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      refused |-> (!wr_valid && !done && $past(state) == ST_IDLE));

   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE && !refused));
endmodule

// File: tb/slot_table_builder_test.sv
`timescale 1ns/1ps
module slot_table_builder_test;
   localparam int NC = 15;
   localparam int NS = 64;
   localparam int CW = 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [NC-1:0]  client_active = '0;
   logic [NC*CW-1:0] client_req = '0;
   logic [CW-1:0]  spare_slots = '0;
   logic           wr_valid;
   logic [5:0]     wr_slot;
   logic [3:0]     wr_client;
   logic           done;
   logic           refused;

   always #2.5 clk = ~clk;

   slot_table_builder uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .client_active(client_active), .client_req(client_req),
      .spare_slots(spare_slots), .wr_valid(wr_valid), .wr_slot(wr_slot),
      .wr_client(wr_client), .done(done), .refused(refused)
   );

   int checks = 0;
   int errors = 0;

   // configuration under test
   int m_req [NC];
   bit m_act [NC];
   int m_spare;
   int exp_tbl [NS];

   // monitor state
   int got [NS];
   int nwr, done_cnt, ref_cnt, cyc, last_slot, last_cyc;
   bit order_bad, done_bad;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (wr_valid) begin
            got[wr_slot] = wr_client;
            if (nwr == 0 && wr_slot != 0) order_bad = 1;
            if (nwr > 0 && (int'(wr_slot) != last_slot + 1 || cyc != last_cyc + 1)) order_bad = 1;
            last_slot = wr_slot;
            last_cyc  = cyc;
            nwr++;
         end
         if (done) begin
            done_cnt++;
            if (cyc != last_cyc + 1 || last_slot != NS - 1) done_bad = 1;
         end
         if (refused) ref_cnt++;
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", wd);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Expected table straight from the requirements R3..R7.
   task automatic build_model();
      int spare = m_spare;
      int c;
      for (int s = 0; s < NS; s++) exp_tbl[s] = -1;
      for (int cl = 0; cl < NC; cl++) begin
         int iv, p;
         if (m_req[cl] == 0) begin
            if (!m_act[cl] || spare <= 0) continue;
            spare--;
            iv = NS;
         end else iv = NS / m_req[cl];
         p = 0;
         while (p < NS) begin
            if (exp_tbl[p] >= 0) p++;
            else begin exp_tbl[p] = cl; p += iv; end
         end
      end
      c = 0;
      for (int s = 0; s < NS; s++) begin
         if (exp_tbl[s] < 0) begin
            int first = c;
            while (!m_act[c]) begin
               c = (c + 1) % NC;
               if (c == first) break;
            end
            exp_tbl[s] = c;
            c = (c + 1) % NC;
         end
      end
   endtask

   task automatic clear_cfg();
      for (int i = 0; i < NC; i++) begin m_req[i] = 0; m_act[i] = 0; end
      m_spare = 0;
   endtask

   task automatic drive_cfg();
      for (int i = 0; i < NC; i++) begin
         client_req[i*CW +: CW] = CW'(m_req[i]);
         client_active[i]       = m_act[i];
      end
      spare_slots = CW'(m_spare);
   endtask

   task automatic clear_mon();
      @(posedge clk);
      nwr = 0; done_cnt = 0; ref_cnt = 0; order_bad = 0; done_bad = 0;
      last_slot = -1; last_cyc = 0;
      for (int s = 0; s < NS; s++) got[s] = -1;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 5000 && done_cnt == 0; i++) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   task automatic check_stream(input string req, input string tag);
      check(nwr == NS, "R8", {tag, " write count"}, nwr, NS);
      check(!order_bad, "R8", {tag, " ascending consecutive slots"}, order_bad, 0);
      check(done_cnt == 1 && !done_bad, "R9", {tag, " done after slot 63"}, done_cnt, 1);
      for (int s = 0; s < NS; s++)
         check(got[s] == exp_tbl[s], req, $sformatf("%s slot %0d", tag, s), got[s], exp_tbl[s]);
   endtask

   task automatic run_and_check(input string req, input string tag);
      build_model();
      clear_mon();
      @(negedge clk) drive_cfg();
      pulse_start();
      wait_done();
      check_stream(req, tag);
   endtask

   // R1: idle after reset
   task automatic t_reset();
      clear_mon();
      repeat (10) @(negedge clk);
      check(!wr_valid && !done && !refused, "R1", "outputs idle after reset",
            {wr_valid, done, refused}, 0);
      check(nwr == 0 && done_cnt == 0 && ref_cnt == 0, "R1", "no activity without start",
            nwr + done_cnt + ref_cnt, 0);
   endtask

   // R3: strided placement with skip-over, inactive nonzero request still placed
   task automatic t_stride();
      clear_cfg();
      m_req[0] = 8; m_req[1] = 4; m_req[2] = 3; m_req[5] = 2;
      for (int i = 0; i < 5; i++) m_act[i] = 1;
      run_and_check("R3", "stride");
      check(got[0] == 0 && got[1] == 1 && got[2] == 2, "R3", "first entries by order",
            got[2], 2);
   endtask

   // R4/R5: spare pool for zero-request active clients
   task automatic t_spare();
      clear_cfg();
      m_req[3] = 16;
      m_act[1] = 1; m_act[3] = 1; m_act[6] = 1; m_act[9] = 1; m_act[12] = 1;
      m_spare = 2;
      run_and_check("R4", "spare2");
      // R5: spare exhausted, zero-request clients skipped in placement
      m_spare = 0;
      run_and_check("R5", "spare0");
      check(got[0] == 3, "R5", "slot 0 owner with no spare", got[0], 3);
   endtask

   // R6: round robin fill over active clients
   task automatic t_rr();
      clear_cfg();
      m_act[2] = 1; m_act[7] = 1; m_act[14] = 1;
      run_and_check("R6", "rr");
      check(got[0] == 2 && got[1] == 7 && got[2] == 14 && got[3] == 2, "R6",
            "rotation 2,7,14,2", got[3], 2);
   endtask

   // R7: no active client anywhere
   task automatic t_none();
      clear_cfg();
      run_and_check("R7", "none");
      check(got[20] == 5 && got[63] == 3, "R7", "slot k gets k mod 15", got[20], 5);
   endtask

   // R2: refusal above 64, acceptance at exactly 64
   task automatic t_refuse();
      clear_cfg();
      m_req[0] = 40; m_req[1] = 25; m_act[0] = 1; m_act[1] = 1;
      clear_mon();
      @(negedge clk) drive_cfg();
      pulse_start();
      repeat (200) @(posedge clk);
      check(ref_cnt == 1, "R2", "refused pulse for total 65", ref_cnt, 1);
      check(nwr == 0 && done_cnt == 0, "R2", "no writes after refusal", nwr + done_cnt, 0);
      clear_cfg();
      m_req[4] = 64; m_act[4] = 1;
      run_and_check("R2", "total64");
      check(ref_cnt == 0, "R2", "total 64 not refused", ref_cnt, 0);
   endtask

   // R10: start while busy is ignored
   task automatic t_busy();
      clear_cfg();
      m_req[0] = 2; m_req[6] = 5; m_act[0] = 1; m_act[6] = 1; m_act[10] = 1;
      m_spare = 1;
      build_model();
      clear_mon();
      @(negedge clk) drive_cfg();
      pulse_start();
      repeat (40) @(negedge clk);
      // different configuration and a second start mid-build
      client_req = '0; client_active = '1; spare_slots = '0;
      pulse_start();
      for (int i = 0; i < 5000 && done_cnt == 0; i++) @(posedge clk);
      repeat (200) @(posedge clk);
      check(ref_cnt == 0, "R10", "no refusal from busy start", ref_cnt, 0);
      check_stream("R10", "busy");
   endtask

   initial begin
      clear_cfg();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stride();
      t_spare();
      t_rr();
      t_none();
      t_refuse();
      t_busy();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule